// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. A shared free-running 64-bit main counter is fed in from outside. The channel compares it against its own comparator register and produces a one-clock fire pulse for the interrupt logic. The channel works in one-shot or periodic mode. In periodic mode it keeps a hidden period register and advances the comparator by that period each time the comparator is reached.

A narrow (32-bit) mode clears the upper halves of the comparator and the period, and compares only the low 32 bits. In narrow one-shot mode the channel also fires when the low counter half wraps. Software writes the comparator through separate low-half and high-half 32-bit strobes. A set-value flag lets those writes reach the comparator directly while the channel is in periodic mode. The comparator, the period and the set-value flag can be read back.

Top module: `etc_channel`

## Requirements
- R1: After a synchronous reset the comparator reads all ones, the period reads 0, the set-value flag reads 0, the channel is disarmed and `fire_o` is 0.
- R2: When the channel is armed and `glb_en_i` is 1, a counter sample equal to the comparator sets `fire_o` for the one clock after that sample. The compare covers all 64 bits in wide mode and only bits 31:0 in narrow mode.
- R3: A 0-to-1 change of `ch_en_i` arms the channel only if `glb_en_i` is 1 in that same cycle. A 1-to-0 change disarms it and suppresses any fire from that cycle. While `glb_en_i` is 0, no fire is produced and the comparator does not advance.
- R4: In periodic mode with the set-value flag at 0, a low-half write loads period bits 31:0 and a high-half write loads period bits 63:32. The comparator is left alone in both cases.
- R5: Writes reach the comparator directly in one-shot mode, and in periodic mode while the set-value flag is 1. A periodic low-half write with the flag at 1 loads both the comparator low half and the period low half. A periodic high-half write with the flag at 1 loads only the comparator high half. Either write clears the flag. A `setval_set_i` pulse sets it, and a pulse in the same cycle as a write wins.
- R6: The top bit of a stored period is forced to 0. This is bit 31 on a low-half write in narrow mode, and bit 63 on a high-half write.
- R7: On a match in periodic mode with a nonzero period, the comparator becomes comparator plus period. With a zero period it does not change, although the fire still occurs.
- R8: In periodic mode with a nonzero period, while the channel is armed and globally enabled, the comparator lags the counter whenever the signed difference (counter minus comparator) is greater than 0. That difference is taken over 32 bits in narrow mode and 64 bits in wide mode. While the comparator lags, the period is added once per clock without any fire.
- R9: While `narrow_i` is 1, bits 63:32 of the comparator and the period read 0 from the next clock onward.
- R10: In narrow one-shot mode, an armed and enabled channel fires when the counter's low 32 bits go from 0xFFFFFFFF in one sample to 0x00000000 in the next. This is in addition to the comparator match.
- R11: A comparator write that falls in the same cycle as a match or catch-up addition overrides the addition. The written half takes the data, the other half keeps its old value, and any fire from the match is still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | Main counter value |
| glb_en_i | input | 1 | Global enable of the timer block |
| ch_en_i | input | 1 | Channel enable configuration bit |
| periodic_i | input | 1 | 1 selects periodic mode, 0 selects one-shot |
| narrow_i | input | 1 | 1 selects 32-bit operation |
| setval_set_i | input | 1 | Pulse that sets the set-value flag |
| cmp_lo_we_i | input | 1 | Write strobe for comparator bits 31:0 |
| cmp_hi_we_i | input | 1 | Write strobe for comparator bits 63:32 |
| wdata_i | input | 32 | Write data for either half |
| fire_o | output | 1 | One-clock fire pulse |
| cmp_o | output | 64 | Comparator readback |
| period_o | output | 64 | Period readback |
| setval_o | output | 1 | Set-value flag readback |

## Verification
Two events can land on the same clock: a software write to the comparator and the hardware update of that comparator, either the periodic reload on a match or a catch-up addition. The bench provokes this directly. It raises the set-value flag and then issues a low-half write in exactly the cycle the counter equals the comparator. It then checks that the written value replaces the sum while the fire pulse still appears. Random stimulus also hits the collision repeatedly, because writes, jumps of the counter to just below the comparator, and mode changes are all mixed. A cycle-by-cycle model built from the requirements judges every outcome.

// File: rtl/etc_pkg.sv
package etc_pkg;

  // Source of the next comparator value
  typedef enum logic [1:0] {
    CMP_HOLD  = 2'd0,
    CMP_WRITE = 2'd1,
    CMP_STEP  = 2'd2
  } cmp_src_e;

  // Channel operating mode as seen by the storage logic
  typedef struct packed {
    logic periodic;
    logic narrow;
  } chan_mode_t;

endpackage

// File: rtl/etc_arm.sv
// Edge detection on the channel enable and the armed state.
module etc_arm (
  input  logic clk,
  input  logic rst,
  input  logic glb_en_i,
  input  logic ch_en_i,
  output logic live_o
);
  logic en_d;
  logic armed_q;
  logic en_rise;
  logic en_fall;

  assign en_rise = ch_en_i & ~en_d;
  assign en_fall = en_d & ~ch_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_d <= ch_en_i;
      if (en_fall)
        armed_q <= 1'b0;
      else if (en_rise && glb_en_i)
        armed_q <= 1'b1;
    end
  end

  // A channel acts only while armed, globally enabled and not disarming now
  assign live_o = armed_q & glb_en_i & ~en_fall;

endmodule

// File: rtl/etc_detect.sv
// Match, lag and low-half wrap detection.
module etc_detect #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             periodic_i,
  input  logic             narrow_i,
  input  logic             live_i,
  output logic             hit_o,
  output logic             wrap_o,
  output logic             behind_o
);
  localparam int HALF_W = CNT_W / 2;

  logic              low_full_q;
  logic [CNT_W-1:0]  diff_w;
  logic [HALF_W-1:0] diff_n;
  logic              eq_w;
  logic              eq_n;
  logic              lag_w;
  logic              lag_n;

  assign diff_w = cnt_i - cmp_i;
  assign diff_n = cnt_i[HALF_W-1:0] - cmp_i[HALF_W-1:0];
  assign eq_w   = (cnt_i == cmp_i);
  assign eq_n   = (cnt_i[HALF_W-1:0] == cmp_i[HALF_W-1:0]);
  assign lag_w  = ($signed(diff_w) > 0);
  assign lag_n  = ($signed(diff_n) > 0);

  // Remembers whether the previous sample had an all-ones low half
  always_ff @(posedge clk) begin
    if (rst)
      low_full_q <= 1'b0;
    else
      low_full_q <= &cnt_i[HALF_W-1:0];
  end

  assign hit_o    = live_i & (narrow_i ? eq_n : eq_w);
  assign behind_o = live_i & (narrow_i ? lag_n : lag_w);
  assign wrap_o   = live_i & narrow_i & ~periodic_i & low_full_q &
                    (cnt_i[HALF_W-1:0] == '0);

endmodule

// File: rtl/etc_store.sv
// Comparator, period and set-value registers.
module etc_store
  import etc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  chan_mode_t            mode_i,
  input  logic                  lo_we_i,
  input  logic                  hi_we_i,
  input  logic [CNT_W/2-1:0]    wdata_i,
  input  logic                  setval_set_i,
  input  logic                  step_i,
  output logic [CNT_W-1:0]      cmp_o,
  output logic [CNT_W-1:0]      per_o,
  output logic                  setval_o
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0]  cmp_q, cmp_n, cmp_w;
  logic [CNT_W-1:0]  per_q, per_n;
  logic              sv_q, sv_n;
  logic              direct;
  logic [HALF_W-1:0] wdata_top0;
  cmp_src_e          src;

  assign direct     = ~mode_i.periodic | sv_q;
  assign wdata_top0 = {1'b0, wdata_i[HALF_W-2:0]};

  // Choose what the comparator takes next
  always_comb begin
    if ((lo_we_i | hi_we_i) && direct)
      src = CMP_WRITE;
    else if (step_i)
      src = CMP_STEP;
    else
      src = CMP_HOLD;
  end

  always_comb begin
    cmp_w = cmp_q;
    if (lo_we_i) cmp_w[HALF_W-1:0]     = wdata_i;
    if (hi_we_i) cmp_w[CNT_W-1:HALF_W] = wdata_i;

    unique case (src)
      CMP_WRITE: cmp_n = cmp_w;
      CMP_STEP:  cmp_n = cmp_q + per_q;
      default:   cmp_n = cmp_q;
    endcase

    per_n = per_q;
    if (mode_i.periodic && lo_we_i)
      per_n[HALF_W-1:0] = mode_i.narrow ? wdata_top0 : wdata_i;
    if (mode_i.periodic && hi_we_i && !sv_q)
      per_n[CNT_W-1:HALF_W] = wdata_top0;

    if (setval_set_i)
      sv_n = 1'b1;
    else if (lo_we_i | hi_we_i)
      sv_n = 1'b0;
    else
      sv_n = sv_q;

    if (mode_i.narrow) begin
      cmp_n[CNT_W-1:HALF_W] = '0;
      per_n[CNT_W-1:HALF_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
      per_q <= '0;
      sv_q  <= 1'b0;
    end else begin
      cmp_q <= cmp_n;
      per_q <= per_n;
      sv_q  <= sv_n;
    end
  end

  assign cmp_o    = cmp_q;
  assign per_o    = per_q;
  assign setval_o = sv_q;

endmodule

// File: rtl/etc_channel.sv
// Top of one event timer comparator channel.
module etc_channel
  import etc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                glb_en_i,
  input  logic                ch_en_i,
  input  logic                periodic_i,
  input  logic                narrow_i,
  input  logic                setval_set_i,
  input  logic                cmp_lo_we_i,
  input  logic                cmp_hi_we_i,
  input  logic [CNT_W/2-1:0]  wdata_i,
  output logic                fire_o,
  output logic [CNT_W-1:0]    cmp_o,
  output logic [CNT_W-1:0]    period_o,
  output logic                setval_o
);
  logic       live;
  logic       hit;
  logic       wrap;
  logic       behind;
  logic       step;
  logic       fire_q;
  chan_mode_t mode;

  assign mode.periodic = periodic_i;
  assign mode.narrow   = narrow_i;

  etc_arm u_arm (
    .clk      (clk),
    .rst      (rst),
    .glb_en_i (glb_en_i),
    .ch_en_i  (ch_en_i),
    .live_o   (live)
  );

  etc_detect #(.CNT_W(CNT_W)) u_det (
    .clk        (clk),
    .rst        (rst),
    .cnt_i      (cnt_i),
    .cmp_i      (cmp_o),
    .periodic_i (periodic_i),
    .narrow_i   (narrow_i),
    .live_i     (live),
    .hit_o      (hit),
    .wrap_o     (wrap),
    .behind_o   (behind)
  );

  // Periodic advance on a match or while the comparator lags
  assign step = periodic_i & (period_o != '0) & (hit | behind);

  etc_store #(.CNT_W(CNT_W)) u_store (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode),
    .lo_we_i      (cmp_lo_we_i),
    .hi_we_i      (cmp_hi_we_i),
    .wdata_i      (wdata_i),
    .setval_set_i (setval_set_i),
    .step_i       (step),
    .cmp_o        (cmp_o),
    .per_o        (period_o),
    .setval_o     (setval_o)
  );

  always_ff @(posedge clk) begin
    if (rst)
      fire_q <= 1'b0;
    else
      fire_q <= hit | wrap;
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/etc_channel_chk.sv
// Property checker attached to every etc_channel instance.
module etc_channel_chk #(
  parameter int CNT_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               glb_en_i,
  input logic               ch_en_i,
  input logic               periodic_i,
  input logic               narrow_i,
  input logic               setval_set_i,
  input logic               cmp_lo_we_i,
  input logic               cmp_hi_we_i,
  input logic               fire_o,
  input logic [CNT_W-1:0]   cmp_o,
  input logic [CNT_W-1:0]   period_o,
  input logic               setval_o
);
  localparam int HALF_W = CNT_W / 2;

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (cmp_o == '1 && period_o == '0 && !setval_o && !fire_o));

  a_r3_no_fire_global_off: assert property (@(posedge clk) disable iff (rst)
    !glb_en_i |=> !fire_o);

  a_r3_no_fire_on_disarm: assert property (@(posedge clk) disable iff (rst)
    $fell(ch_en_i) |=> !fire_o);

  a_r5_setval_clears: assert property (@(posedge clk) disable iff (rst)
    ((cmp_lo_we_i || cmp_hi_we_i) && !setval_set_i) |=> !setval_o);

  a_r5_setval_sets: assert property (@(posedge clk) disable iff (rst)
    setval_set_i |=> setval_o);

  a_r6_period_top_clear: assert property (@(posedge clk) disable iff (rst)
    (periodic_i && !setval_o && cmp_hi_we_i) |=> !period_o[CNT_W-1]);

  a_r9_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    narrow_i |=> (cmp_o[CNT_W-1:HALF_W] == '0 && period_o[CNT_W-1:HALF_W] == '0));

endmodule

bind etc_channel etc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .glb_en_i     (glb_en_i),
  .ch_en_i      (ch_en_i),
  .periodic_i   (periodic_i),
  .narrow_i     (narrow_i),
  .setval_set_i (setval_set_i),
  .cmp_lo_we_i  (cmp_lo_we_i),
  .cmp_hi_we_i  (cmp_hi_we_i),
  .fire_o       (fire_o),
  .cmp_o        (cmp_o),
  .period_o     (period_o),
  .setval_o     (setval_o)
);

// File: tb/etc_channel_test.sv
module etc_channel_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cnt_r = '0;
  logic        glb_r = 1'b0, chen_r = 1'b0, per_r = 1'b0, nar_r = 1'b0;
  logic        sv_r = 1'b0, lo_r = 1'b0, hi_r = 1'b0;
  logic [31:0] wd_r = '0;
  logic        fire_o, setval_o;
  logic [63:0] cmp_o, period_o;

  int n_chk = 0;
  int n_fail = 0;

  // Reference state built from the requirements
  logic [63:0] m_cmp, m_per;
  logic        m_sv, m_arm, m_end, m_pff, m_fire;

  always #5 clk = ~clk;

  etc_channel uut (
    .clk(clk), .rst(rst), .cnt_i(cnt_r), .glb_en_i(glb_r), .ch_en_i(chen_r),
    .periodic_i(per_r), .narrow_i(nar_r), .setval_set_i(sv_r),
    .cmp_lo_we_i(lo_r), .cmp_hi_we_i(hi_r), .wdata_i(wd_r),
    .fire_o(fire_o), .cmp_o(cmp_o), .period_o(period_o), .setval_o(setval_o)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic fall, rise, live, hit, lag, wrap, step, direct;
    logic [31:0] d32;
    logic [63:0] d64, cw, pn;
    if (rst) begin
      m_cmp = '1; m_per = '0; m_sv = 0; m_arm = 0; m_end = 0; m_pff = 0; m_fire = 0;
      return;
    end
    fall = m_end & ~chen_r;
    rise = chen_r & ~m_end;
    live = m_arm & glb_r & ~fall;
    hit  = live & (nar_r ? (cnt_r[31:0] == m_cmp[31:0]) : (cnt_r == m_cmp));
    d32  = cnt_r[31:0] - m_cmp[31:0];
    d64  = cnt_r - m_cmp;
    lag  = live & (nar_r ? ($signed(d32) > 0) : ($signed(d64) > 0));
    wrap = live & nar_r & ~per_r & m_pff & (cnt_r[31:0] == 32'h0);
    step = per_r & (m_per != 0) & (hit | lag);
    direct = ~per_r | m_sv;
    cw = m_cmp;
    if (lo_r) cw[31:0]  = wd_r;
    if (hi_r) cw[63:32] = wd_r;
    pn = m_per;
    if (per_r && lo_r) pn[31:0] = nar_r ? {1'b0, wd_r[30:0]} : wd_r;
    if (per_r && hi_r && !m_sv) pn[63:32] = {1'b0, wd_r[30:0]};
    if ((lo_r || hi_r) && direct) m_cmp = cw;
    else if (step) m_cmp = m_cmp + m_per;
    m_per = pn;
    if (sv_r) m_sv = 1;
    else if (lo_r || hi_r) m_sv = 0;
    if (nar_r) begin
      m_cmp[63:32] = '0;
      m_per[63:32] = '0;
    end
    m_fire = hit | wrap;
    if (fall) m_arm = 0;
    else if (rise && glb_r) m_arm = 1;
    m_end = chen_r;
    m_pff = &cnt_r[31:0];
  endtask

  // One clock: advance the model, clock the design, compare, clear strobes
  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    #1;
    chk(tag, "fire", {63'd0, fire_o}, {63'd0, m_fire});
    chk(tag, "cmp", cmp_o, m_cmp);
    chk(tag, "period", period_o, m_per);
    chk(tag, "setval", {63'd0, setval_o}, {63'd0, m_sv});
    lo_r = 0; hi_r = 0; sv_r = 0;
  endtask

  task automatic tick(string tag);
    cyc(tag);
    cnt_r = cnt_r + 64'd1;
  endtask

  task automatic wr_lo(string tag, logic [31:0] d);
    lo_r = 1; wd_r = d; tick(tag);
  endtask

  task automatic wr_hi(string tag, logic [31:0] d);
    hi_r = 1; wd_r = d; tick(tag);
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual %0d cycles expected fewer", 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1;
    cyc("R1"); cyc("R1");
    rst = 0;
    cyc("R1");
    chk("R1", "cmp reset", cmp_o, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1", "period reset", period_o, 64'h0);

    // R2: wide one-shot match
    glb_r = 1; chen_r = 1; tick("R2");
    wr_lo("R2", 32'd100);
    wr_hi("R2", 32'd0);
    cnt_r = 64'd90;
    run("R2", 20);

    // R3: global disable, arming with global off, disarm at match
    glb_r = 0; cnt_r = 64'd95; run("R3", 10);
    glb_r = 1; chen_r = 0; tick("R3");
    wr_lo("R3", 32'd120);
    glb_r = 0; chen_r = 1; tick("R3");
    glb_r = 1; cnt_r = 64'd115; run("R3", 10);
    chen_r = 0; tick("R3");
    chen_r = 1; tick("R3");
    cnt_r = 64'd115; run("R3", 10);
    chen_r = 0; tick("R3"); chen_r = 1; tick("R3");
    wr_lo("R3", 32'd130);
    cnt_r = 64'd128; tick("R3"); tick("R3");
    chen_r = 0; tick("R3");
    run("R3", 4);
    chen_r = 1; tick("R3");

    // R4 / R5 / R7: periodic loading and reload
    per_r = 1;
    sv_r = 1; tick("R5");
    wr_lo("R5", 32'd50);
    wr_hi("R4", 32'd0);
    cnt_r = 64'd40; run("R7", 130);
    wr_lo("R4", 32'd70);
    wr_hi("R6", 32'hFFFF_FFFF);
    chk("R6", "period top", {63'd0, period_o[63]}, 64'd0);
    wr_hi("R4", 32'd0);
    sv_r = 1; tick("R5");
    wr_hi("R5", 32'd0);
    nar_r = 1; tick("R9");
    wr_lo("R6", 32'hFFFF_FFFF);
    chk("R6", "narrow period", period_o, 64'h0000_0000_7FFF_FFFF);
    nar_r = 0;
    wr_lo("R8", 32'd50);

    // R8: catch-up after a forward jump
    cnt_r = cmp_o + 64'd1000; run("R8", 40);
    // R7: zero period, fire without advance
    wr_lo("R7", 32'd0);
    cnt_r = cmp_o - 64'd2; run("R7", 6);

    // R9 / R10: narrow one-shot with low-half wrap
    per_r = 0; nar_r = 1; tick("R9");
    wr_lo("R10", 32'h10);
    cnt_r = 64'h5_FFFF_FFF8; run("R10", 30);
    chk("R9", "cmp upper", {32'd0, cmp_o[63:32]}, 64'd0);

    // R11: write in the same cycle as a periodic match
    nar_r = 0; per_r = 1;
    sv_r = 1; tick("R11");
    wr_lo("R11", 32'd300);
    wr_hi("R11", 32'd0);
    cnt_r = 64'd296; tick("R11"); tick("R11");
    sv_r = 1; tick("R11");
    tick("R11");
    wr_lo("R11", 32'd1000);
    run("R11", 4);

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 70)       cnt_r = cnt_r + 64'd1;
      else if (r < 82)  cnt_r = {cmp_o[63:32], cmp_o[31:0] - ($urandom % 4)};
      else if (r < 90)  cnt_r = {cnt_r[63:32], 32'hFFFF_FFFC};
      else if (r < 95)  cnt_r = cnt_r + ($urandom % 500);
      else              cnt_r = {$urandom, $urandom};
      if ($urandom % 20 == 0) begin
        wd_r = ($urandom % 4 == 0) ? $urandom : ($urandom % 64);
        if ($urandom % 2 == 0) lo_r = 1; else hi_r = 1;
      end
      if ($urandom % 30 == 0) sv_r = 1;
      if ($urandom % 50 == 0) chen_r = ~chen_r;
      if ($urandom % 120 == 0) glb_r = ~glb_r;
      if ($urandom % 150 == 0) per_r = ~per_r;
      if ($urandom % 150 == 0) nar_r = ~nar_r;
      rst = ($urandom % 800 == 0);
      cyc("R2");
      rst = 0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule